// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block is a word-addressed register bank over a 4 KB window that holds system-level control settings. Most of its registers are protected: a single lock flag, set out of reset, discards every write to them until software writes a specific 16-bit key to the unlock word. Writing a second key to the lock word closes the bank again. Reads are never blocked, so software can always inspect the current settings.

The bottom four words of the window are special. Word 0x0 is a one-bit control register that can always be written. Word 0x4 takes the lock key and word 0x8 takes the unlock key; both read as zero. Word 0xC reports the lock flag. Two protected groups follow. Group A at 0x100 has eight words with fixed reset values, and one of them (0x10C) is a read-only status word. Group B at 0x600 has nine words, and 0x604 is a hole. Every write that is rejected raises a one-cycle error pulse. That covers a wrong key, a locked bank, a read-only word, the hole and an unmapped address.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After reset the lock flag is 1 and the one-bit control register is 0. Group A words 0..2 (offsets 0x100..0x108) read 0x0001A008, word 3 (0x10C) reads 0x0000003F, words 4..6 (0x110..0x118) read 0x00014000, and word 7 (0x11C) reads 0. All group B words read 0.
- R2: A write to offset 0x4 whose bits [15:0] equal 0x767B sets the lock flag, whatever bits [31:16] hold. Any other value leaves the flag unchanged and is rejected.
- R3: A write to offset 0x8 whose bits [15:0] equal 0xDF0D clears the lock flag, whatever bits [31:16] hold. Any other value leaves the flag unchanged and is rejected.
- R4: A read of offset 0xC returns the lock flag in bit 0, with bits [31:1] zero. A write to 0xC changes nothing and is rejected. Reads of 0x4 and 0x8 return 0.
- R5: Offset 0x0 stores bit 0 of the write data and reads it back in bit 0, with the other bits zero. It is writable whether the bank is locked or not, and a write to it is never rejected.
- R6: While the lock flag is 1, every write to group A or group B is discarded and rejected, and reads return the unchanged values.
- R7: While the lock flag is 0, a write to a writable word of group A or group B stores all 32 data bits, and a later read returns them.
- R8: The status word at 0x10C ignores writes and rejects them even while the bank is unlocked.
- R9: Offset 0x604 is a hole. It reads 0, and a write to it is ignored and rejected, leaving every other word unchanged.
- R10: An offset outside the mapped words reads 0. A write to it changes no register and is rejected.
- R11: A read request produces `rsp_valid` high with its data exactly one cycle later. A write request produces no `rsp_valid`. Address bits [1:0] do not affect which word is selected.
- R12: `wr_err` is high for exactly the one cycle after a rejected write request and is low at every other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest states to reach from the ports are the combinations of the lock flag with each kind of address. The read-only status word and the hole must be shown to reject writes even while the bank is unlocked, and the control bit must be shown to accept writes while it is locked. The stimulus therefore writes a distinct pattern to every word address in the window twice, once with the bank locked and once after the unlock key, and sweeps reads over all 1024 words after reset and after each write pass. A bench model predicts every read value and every error pulse. Separate sequences cover near-miss keys and keys with arbitrary upper halves.

// File: rtl/keyed_bank_pkg.sv
package keyed_bank_pkg;
    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int IDX_W = 8;

    localparam logic [15:0] CLOSE_KEY = 16'h767B;
    localparam logic [15:0] OPEN_KEY  = 16'hDF0D;

    typedef enum logic [2:0] {
        SEL_CTL,
        SEL_CLOSE,
        SEL_OPEN,
        SEL_STAT,
        SEL_GRPA,
        SEL_GRPB,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
        logic             ro;
    } dec_t;

    typedef struct packed {
        logic          rsp_v;
        logic [DW-1:0] rdata;
        logic          err;
        logic          ctl;
    } port_state_t;

    // Reset contents: group 0 carries fixed settings, group 1 starts cleared
    function automatic logic [DW-1:0] rst_word(input int grp, input int i);
        if (grp != 0) return '0;
        if (i <= 2)   return 32'h0001_A008;
        if (i == 3)   return 32'h0000_003F;
        if (i <= 6)   return 32'h0001_4000;
        return '0;
    endfunction
endpackage

// File: rtl/kb_decode.sv
module kb_decode
    import keyed_bank_pkg::*;
#(
    parameter int GRPA_BASE   = 'h100,
    parameter int GRPA_WORDS  = 8,
    parameter int GRPA_RO_IDX = 3,
    parameter int GRPB_BASE   = 'h600,
    parameter int GRPB_WORDS  = 9,
    parameter int GRPB_HOLE   = 1
) (
    input  logic [AW-3:0] word,
    output dec_t          dec
);
    localparam int A_LO = GRPA_BASE / 4;
    localparam int B_LO = GRPB_BASE / 4;

    always_comb begin
        int w;
        w   = int'(word);
        dec = '{sel: SEL_NONE, idx: '0, ro: 1'b0};
        if (w == 0) begin
            dec.sel = SEL_CTL;
        end else if (w == 1) begin
            dec.sel = SEL_CLOSE;
        end else if (w == 2) begin
            dec.sel = SEL_OPEN;
        end else if (w == 3) begin
            dec.sel = SEL_STAT;
        end else if (w >= A_LO && w < A_LO + GRPA_WORDS) begin
            dec.sel = SEL_GRPA;
            dec.idx = IDX_W'(w - A_LO);
            dec.ro  = (w - A_LO) == GRPA_RO_IDX;
        end else if (w >= B_LO && w < B_LO + GRPB_WORDS && (w - B_LO) != GRPB_HOLE) begin
            dec.sel = SEL_GRPB;
            dec.idx = IDX_W'(w - B_LO);
        end
    end
endmodule

// File: rtl/kb_lock.sv
module kb_lock
    import keyed_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        close_wr,
    input  logic        open_wr,
    input  logic [15:0] key,
    output logic        locked,
    output logic        key_bad
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d  = lock_q;
        key_bad = 1'b0;
        if (close_wr) begin
            if (key == CLOSE_KEY) lock_d = 1'b1;
            else                  key_bad = 1'b1;
        end
        if (open_wr) begin
            if (key == OPEN_KEY) lock_d = 1'b0;
            else                 key_bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b1;
        else        lock_q <= lock_d;
    end

    assign locked = lock_q;
endmodule

// File: rtl/kb_regfile.sv
module kb_regfile
    import keyed_bank_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int GRP   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (we && int'(idx) == i) mem_d[i] = wdata;
            if (int'(idx) == i)       rdata    = mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= rst_word(GRP, i);
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
    import keyed_bank_pkg::*;
#(
    parameter int GRPA_BASE   = 'h100,
    parameter int GRPA_WORDS  = 8,
    parameter int GRPA_RO_IDX = 3,
    parameter int GRPB_BASE   = 'h600,
    parameter int GRPB_WORDS  = 9,
    parameter int GRPB_HOLE   = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        wr_err
);
    dec_t          dec;
    port_state_t   st_d, st_q;
    logic          wr, rd, locked, key_bad, we_a, we_b;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          unused_addr_bits;

    assign unused_addr_bits = ^req_addr[1:0];
    assign wr = req_valid && req_we;
    assign rd = req_valid && !req_we;

    kb_decode #(
        .GRPA_BASE(GRPA_BASE), .GRPA_WORDS(GRPA_WORDS), .GRPA_RO_IDX(GRPA_RO_IDX),
        .GRPB_BASE(GRPB_BASE), .GRPB_WORDS(GRPB_WORDS), .GRPB_HOLE(GRPB_HOLE)
    ) u_dec (
        .word (req_addr[AW-1:2]),
        .dec  (dec)
    );

    kb_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .close_wr (wr && dec.sel == SEL_CLOSE),
        .open_wr  (wr && dec.sel == SEL_OPEN),
        .key      (req_wdata[15:0]),
        .locked   (locked),
        .key_bad  (key_bad)
    );

    assign we_a = wr && dec.sel == SEL_GRPA && !locked && !dec.ro;
    assign we_b = wr && dec.sel == SEL_GRPB && !locked;

    kb_regfile #(.WORDS(GRPA_WORDS), .GRP(0)) u_grpa (
        .clk(clk), .rst_n(rst_n), .we(we_a), .idx(dec.idx),
        .wdata(req_wdata), .rdata(a_rdata)
    );

    kb_regfile #(.WORDS(GRPB_WORDS), .GRP(1)) u_grpb (
        .clk(clk), .rst_n(rst_n), .we(we_b), .idx(dec.idx),
        .wdata(req_wdata), .rdata(b_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = rd;
        st_d.err   = 1'b0;
        if (rd) begin
            unique case (dec.sel)
                SEL_CTL:  st_d.rdata = {{(DW-1){1'b0}}, st_q.ctl};
                SEL_STAT: st_d.rdata = {{(DW-1){1'b0}}, locked};
                SEL_GRPA: st_d.rdata = a_rdata;
                SEL_GRPB: st_d.rdata = b_rdata;
                default:  st_d.rdata = '0;
            endcase
        end
        if (wr) begin
            unique case (dec.sel)
                SEL_CTL:              st_d.ctl = req_wdata[0];
                SEL_CLOSE, SEL_OPEN:  st_d.err = key_bad;
                SEL_GRPA:             st_d.err = locked || dec.ro;
                SEL_GRPB:             st_d.err = locked;
                default:              st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rdata;
    assign wr_err    = st_q.err;
endmodule

// File: rtl/kb_checker.sv
module kb_checker #(
    parameter int GRPB_BASE  = 'h600,
    parameter int GRPB_WORDS = 9
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_we,
    input logic [11:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        wr_err
);
    localparam int TOP_WORD = GRPB_BASE / 4 + GRPB_WORDS;

    logic rd_req, wr_req;
    assign rd_req = req_valid && !req_we;
    assign wr_req = req_valid && req_we;

    assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    assert_no_rsp_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    assert_err_needs_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_req));

    assert_ctl_never_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_addr[11:2] == 10'd0) |=> !wr_err);

    assert_stat_write_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_addr[11:2] == 10'd3) |=> wr_err);

    assert_key_words_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (req_addr[11:2] == 10'd1 || req_addr[11:2] == 10'd2)) |=> rsp_rdata == 32'd0);

    assert_lock_status_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr[11:2] == 10'd3) |=> rsp_rdata[31:1] == 31'd0);

    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(req_addr[11:2]) >= TOP_WORD) |=> rsp_rdata == 32'd0);

    assert_unmapped_write_rejected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && int'(req_addr[11:2]) >= TOP_WORD) |=> wr_err);
endmodule

bind keyed_ctrl_bank kb_checker #(
    .GRPB_BASE  (GRPB_BASE),
    .GRPB_WORDS (GRPB_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .wr_err    (wr_err)
);

// File: tb/sim_keyed_ctrl_bank.sv
`timescale 1ns/1ps
module sim_keyed_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        wr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_a [8];
    logic [31:0] m_b [9];
    bit          m_lock;
    bit          m_ctl;

    always #10 clk = ~clk;

    keyed_ctrl_bank u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .wr_err(wr_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected read data, from the requirement text
    function automatic logic [31:0] model_read(input int w);
        if (w == 0)                return {31'd0, m_ctl};
        if (w == 1 || w == 2)      return 32'd0;
        if (w == 3)                return {31'd0, m_lock};
        if (w >= 'h40 && w < 'h48) return m_a[w - 'h40];
        if (w == 'h181)            return 32'd0;
        if (w >= 'h180 && w < 'h189) return m_b[w - 'h180];
        return 32'd0;
    endfunction

    // Applies a write to the model and returns the expected rejection flag
    function automatic bit model_write(input int w, input logic [31:0] d);
        if (w == 0) begin m_ctl = d[0]; return 0; end
        if (w == 1) begin
            if (d[15:0] == 16'h767B) begin m_lock = 1; return 0; end
            return 1;
        end
        if (w == 2) begin
            if (d[15:0] == 16'hDF0D) begin m_lock = 0; return 0; end
            return 1;
        end
        if (w == 3) return 1;
        if (w >= 'h40 && w < 'h48) begin
            if (m_lock || w == 'h43) return 1;
            m_a[w - 'h40] = d;
            return 0;
        end
        if (w >= 'h180 && w < 'h189) begin
            if (w == 'h181 || m_lock) return 1;
            m_b[w - 'h180] = d;
            return 0;
        end
        return 1;
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             output logic err_o, output logic rv_o);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        err_o = wr_err;
        rv_o  = rsp_valid;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d_o,
                            output logic rv_o);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d_o  = rsp_rdata;
        rv_o = rsp_valid;
    endtask

    task automatic write_and_check(input string req, input int w, input logic [31:0] d);
        logic e, v;
        bit   exp_e;
        exp_e = model_write(w, d);
        bus_write(12'(w * 4), d, e, v);
        check(req, $sformatf("wr_err @%03h", w * 4), {31'd0, e}, {31'd0, exp_e});
        check("R11", $sformatf("no rsp after write @%03h", w * 4), {31'd0, v}, 32'd0);
    endtask

    task automatic read_sweep(input string req);
        logic [31:0] d;
        logic        v;
        for (int w = 0; w < 1024; w++) begin
            bus_read(12'(w * 4), d, v);
            check(req, $sformatf("read @%03h", w * 4), d, model_read(w));
            check("R11", $sformatf("rsp_valid @%03h", w * 4), {31'd0, v}, 32'd1);
        end
    endtask

    task automatic write_sweep(input string req);
        for (int w = 0; w < 1024; w++) begin
            if (w != 1 && w != 2)
                write_and_check(req, w, 32'h9E37_0000 + 32'(w) * 32'h0001_0003);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog: got %0d cycles expected completion", 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        v, e;

        for (int i = 0; i < 8; i++) m_a[i] = (i <= 2) ? 32'h0001_A008 :
                                             (i == 3) ? 32'h0000_003F :
                                             (i <= 6) ? 32'h0001_4000 : 32'd0;
        for (int i = 0; i < 9; i++) m_b[i] = 32'd0;
        m_lock = 1; m_ctl = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents across the whole window (also R4, R10 reads)
        read_sweep("R1");

        // R6: locked bank rejects every protected write; R5 bit still writes
        write_sweep("R6");
        read_sweep("R6");

        // R3: near-miss unlock keys keep the bank locked
        write_and_check("R3", 2, 32'h0000_DF0C);
        write_and_check("R3", 2, 32'hDF0D_0000);
        bus_read(12'h00C, d, v);
        check("R3", "lock flag after bad keys", d, 32'd1);
        // R12: the pulse lasts one cycle
        @(negedge clk);
        check("R12", "wr_err idle cycle", {31'd0, wr_err}, 32'd0);

        // R3: correct key with arbitrary upper half
        write_and_check("R3", 2, 32'hFFFF_DF0D);
        bus_read(12'h00C, d, v);
        check("R3", "lock flag after unlock", d, 32'd0);

        // R7: unlocked writes land, except read-only word (R8) and hole (R9)
        write_sweep("R7");
        read_sweep("R7");

        // R8: read-only status word
        write_and_check("R8", 'h43, 32'h1234_5678);
        bus_read(12'h10C, d, v);
        check("R8", "status word", d, 32'h0000_003F);

        // R9: hole, neighbours intact
        write_and_check("R9", 'h181, 32'hFFFF_FFFF);
        bus_read(12'h604, d, v);
        check("R9", "hole reads zero", d, 32'd0);
        bus_read(12'h600, d, v);
        check("R9", "word below hole", d, model_read('h180));
        bus_read(12'h608, d, v);
        check("R9", "word above hole", d, model_read('h182));

        // R10: unmapped write leaves group data alone
        write_and_check("R10", 'h3FF, 32'hDEAD_BEEF);
        bus_read(12'hFFC, d, v);
        check("R10", "unmapped read", d, 32'd0);

        // R11: low address bits ignored
        bus_read(12'h107, d, v);
        check("R11", "read @107", d, model_read('h41));
        bus_read(12'h00F, d, v);
        check("R11", "read @00F", d, 32'd0);

        // R4: status word write ignored
        write_and_check("R4", 3, 32'hFFFF_FFFF);
        bus_read(12'h00C, d, v);
        check("R4", "lock flag after status write", d, 32'd0);

        // R2: near-miss lock key, then correct key with arbitrary upper half
        write_and_check("R2", 1, 32'h0000_767A);
        bus_read(12'h00C, d, v);
        check("R2", "still unlocked", d, 32'd0);
        write_and_check("R2", 1, 32'h5555_767B);
        bus_read(12'h00C, d, v);
        check("R2", "locked again", d, 32'd1);

        // R5: control bit writable while locked, only bit 0 kept
        write_and_check("R5", 0, 32'hFFFF_FFFF);
        bus_read(12'h000, d, v);
        check("R5", "ctl set", d, 32'd1);
        write_and_check("R5", 0, 32'hFFFF_FFFE);
        bus_read(12'h000, d, v);
        check("R5", "ctl clear", d, 32'd0);

        // R6: locked again, a protected write is dropped
        write_and_check("R6", 'h40, 32'h0BAD_F00D);
        bus_read(12'h100, d, v);
        check("R6", "group A word 0 kept", d, model_read('h40));

        // R12: a read after a rejected write sees no pulse
        bus_write(12'h800, 32'd1, e, v);
        check("R12", "pulse after unmapped write", {31'd0, e}, 32'd1);
        bus_read(12'h000, d, v);
        check("R12", "no pulse after read", {31'd0, wr_err}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule